// File: doc/BRIEF.md
# Signed Iterative Remainder Unit

This block divides one two's-complement integer by another and returns only the remainder, together with a flag raised when the divisor is zero. It works like long division on paper. Both operands are first turned into magnitudes. Then, for each of the WORD_W bit positions, from the most significant down, the next dividend bit is shifted into a running partial remainder, and the divisor magnitude is subtracted on trial. The trial result is kept only when it does not go negative. At the end the remainder is given the sign of the dividend.

The trial subtraction is not done by one wide subtractor. A single SLICE_W-bit slice subtractor walks across the (WORD_W+1)-bit operands one slice per cycle and carries a borrow from slice to slice. This keeps the carry chain short, at the cost of several cycles per step.

For every step the unit sends a one-bit success token to a companion quotient builder, on its own valid/ready control port. The unit waits on that port: it does not start the next step until the current token has been accepted. Operands arrive over a valid/ready input port. The result leaves over a valid/ready output port and is held there until it is taken. A synchronous clear abandons any operation in progress.

Top module: `sirem_unit`

## Requirements
- R1: When the divisor is non-zero, out_rem equals |dividend| mod |divisor| carrying the dividend's sign. Examples: 22,7 gives 1; -22,7 gives -1; 22,-7 gives 1; -22,-7 gives -1.
- R2: When |dividend| < |divisor|, out_rem equals the dividend unchanged. Examples: 7,22 gives 7; -7,-22 gives -7; -7,22 gives -7.
- R3: When the divisor is zero, out_dbz is 1 and out_rem is |dividend| with no sign applied: 0 gives 0, 22 gives 22, -22 gives 22. Every token of that operation is 1.
- R4: Each operation emits exactly WORD_W tokens, all before out_valid rises. Token k (k = 0 first) is bit WORD_W-1-k of |dividend| / |divisor|: a 1 means the trial subtraction was kept. out_valid rises in the cycle after the last token is accepted.
- R5: While tok_valid is high and tok_ready is low, tok_valid stays high, tok_ok stays stable and the operation does not advance.
- R6: in_ready is high exactly when no operation is in progress and no result is pending. Operands are captured only on an in_valid/in_ready handshake. Values and in_valid pulses presented while in_ready is low have no effect.
- R7: Once out_valid is high, out_valid, out_rem and out_dbz stay stable until out_ready is seen. out_dbz is 0 for a non-zero divisor. After the output handshake the unit is idle in the next cycle.
- R8: With tok_ready held high, each step takes ceil((WORD_W+1)/SLICE_W)+1 cycles. out_valid therefore rises WORD_W*(ceil((WORD_W+1)/SLICE_W)+1) clock edges after the input handshake edge.
- R9: A cycle with rst high leaves the unit idle at the next edge: in_ready high, out_valid low, tok_valid low. Any operation in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear, active high |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Unit idle and able to take operands |
| dividend | input | WORD_W | Signed dividend |
| divisor | input | WORD_W | Signed divisor |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_rem | output | WORD_W | Signed remainder |
| out_dbz | output | 1 | Divisor was zero |
| tok_valid | output | 1 | Step token available |
| tok_ready | input | 1 | Quotient builder takes the token |
| tok_ok | output | 1 | Trial subtraction of this step was kept |

## Verification
The bench targets four groups of cases: the four sign combinations, a dividend smaller in magnitude than the divisor, a zero divisor, and the most negative value used as either operand. A design that put the divisor's sign on the remainder, or applied sign correction after a zero divisor, would return a remainder with the wrong sign. A design that lost the borrow between slices would keep the wrong trial results, so both the token sequence and the remainder would come out wrong. Random back-pressure on both the token port and the output port exposes a unit that advances past an unaccepted token or changes a held result. Operand changes while the unit is busy, and a clear issued mid-operation, expose capture or recovery faults.

// File: rtl/sirem_pkg.sv
package sirem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUB  = 2'd1,
    ST_TOK  = 2'd2,
    ST_DONE = 2'd3
  } sirem_state_e;
endpackage

// File: rtl/sirem_abs.sv
module sirem_abs #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] mag,
  output logic         neg
);
  // The most negative value maps onto 2**(W-1) read as unsigned.
  always_comb begin
    neg = val[W-1];
    mag = neg ? (~val + W'(1)) : val;
  end
endmodule

// File: rtl/sirem_slice_sub.sv
module sirem_slice_sub #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          bin,
  output logic [SW-1:0] d,
  output logic          bout
);
  logic [SW:0] wide;
  always_comb begin
    wide = {1'b0, a} - {1'b0, b} - {{SW{1'b0}}, bin};
    d    = wide[SW-1:0];
    bout = wide[SW];
  end
endmodule

// File: rtl/sirem_unit.sv
module sirem_unit
  import sirem_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SLICE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] dividend,
  input  logic [WORD_W-1:0] divisor,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_rem,
  output logic              out_dbz,
  output logic              tok_valid,
  input  logic              tok_ready,
  output logic              tok_ok
);
  localparam int PW     = WORD_W + 1;
  localparam int NSLICE = (PW + SLICE_W - 1) / SLICE_W;
  localparam int SUB_W  = NSLICE * SLICE_W;
  localparam int SIDX_W = (NSLICE > 1) ? $clog2(NSLICE) : 1;
  localparam int STEP_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  sirem_state_e      state;
  logic [WORD_W-1:0] a_sh, b_mag, part;
  logic              neg_q, dbz_q, borrow, ok_q;
  logic [SIDX_W-1:0] sidx;
  logic [STEP_W-1:0] step;
  logic [SLICE_W-1:0] diff_a [NSLICE];

  // operand magnitudes
  logic [WORD_W-1:0] a_mag_in, b_mag_in;
  logic              a_neg_in, b_neg_unused;
  sirem_abs #(.W(WORD_W)) u_abs_a (.val(dividend), .mag(a_mag_in), .neg(a_neg_in));
  sirem_abs #(.W(WORD_W)) u_abs_b (.val(divisor),  .mag(b_mag_in), .neg(b_neg_unused));

  // shifted partial remainder and padded operands, cut into slices
  logic [PW-1:0]     psh;
  logic [SUB_W-1:0]  psh_ext, b_ext, diff_flat;
  logic [SLICE_W-1:0] pa [NSLICE];
  logic [SLICE_W-1:0] pb [NSLICE];
  assign psh     = {part, a_sh[WORD_W-1]};
  assign psh_ext = SUB_W'(psh);
  assign b_ext   = SUB_W'(b_mag);

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    assign pa[g] = psh_ext[g*SLICE_W +: SLICE_W];
    assign pb[g] = b_ext[g*SLICE_W +: SLICE_W];
    assign diff_flat[g*SLICE_W +: SLICE_W] = diff_a[g];
  end

  logic [SLICE_W-1:0] s_d;
  logic               s_bout;
  sirem_slice_sub #(.SW(SLICE_W)) u_sub (
    .a(pa[sidx]), .b(pb[sidx]), .bin(borrow), .d(s_d), .bout(s_bout)
  );

  logic last_slice, last_step;
  assign last_slice = (sidx == SIDX_W'(NSLICE - 1));
  assign last_step  = (step == STEP_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          a_sh   <= a_mag_in;
          b_mag  <= b_mag_in;
          part   <= '0;
          neg_q  <= a_neg_in;
          dbz_q  <= (divisor == '0);
          step   <= '0;
          sidx   <= '0;
          borrow <= 1'b0;
          state  <= ST_SUB;
        end
        ST_SUB: begin
          diff_a[sidx] <= s_d;
          borrow       <= s_bout;
          if (last_slice) begin
            ok_q  <= ~s_bout;
            state <= ST_TOK;
          end else begin
            sidx <= sidx + SIDX_W'(1);
          end
        end
        ST_TOK: if (tok_ready) begin
          part   <= ok_q ? diff_flat[WORD_W-1:0] : psh[WORD_W-1:0];
          a_sh   <= a_sh << 1;
          sidx   <= '0;
          borrow <= 1'b0;
          if (last_step) begin
            state <= ST_DONE;
          end else begin
            step  <= step + STEP_W'(1);
            state <= ST_SUB;
          end
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign tok_valid = (state == ST_TOK);
  assign tok_ok    = ok_q;
  assign out_valid = (state == ST_DONE);
  assign out_dbz   = dbz_q;
  assign out_rem   = (neg_q && !dbz_q) ? (~part + WORD_W'(1)) : part;

  // ---------------- assertions ----------------
  logic [STEP_W:0] ck_toks;
  always_ff @(posedge clk) begin
    if (rst || (in_valid && in_ready)) ck_toks <= '0;
    else if (tok_valid && tok_ready)   ck_toks <= ck_toks + (STEP_W+1)'(1);
  end

  assert_tok_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_ok)));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rem) && $stable(out_dbz)));

  assert_token_count_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ck_toks == (STEP_W+1)'(WORD_W)));

  assert_dbz_tokens_R3: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && dbz_q) |-> tok_ok);

  // a kept trial result always fits in the partial remainder (R1)
  assert_commit_fits_R1: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_ok) |-> (diff_flat[SUB_W-1:WORD_W] == '0));

  assert_clear_idle_R9: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid && !tok_valid));
endmodule

// File: tb/test_sirem_unit.sv
module test_sirem_unit;
  localparam int W = 16;
  localparam int S = 4;
  localparam int NSL = (W + 1 + S - 1) / S;
  localparam int STEP_CYC = NSL + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0, tok_ready = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic in_ready, out_valid, out_dbz, tok_valid, tok_ok;
  logic [W-1:0] out_rem;

  always #2.5 clk = ~clk;

  sirem_unit #(.WORD_W(W), .SLICE_W(S)) i_sirem_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .out_valid(out_valid),
    .out_ready(out_ready), .out_rem(out_rem), .out_dbz(out_dbz),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_ok(tok_ok)
  );

  int compared = 0, mismatched = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // stall pattern for tok_ready / out_ready
  bit stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tok_ready <= stall_mode ? lfsr[3] : 1'b1;
    out_ready <= stall_mode ? lfsr[7] : 1'b1;
  end

  // reference model state
  bit            busy = 0;
  int            toks = 0;
  logic [W-1:0]  exp_q, exp_rem;
  bit            exp_dbz;
  longint        edge_cnt = 0, hs_edge = 0;
  bit            lat_checked = 0;
  bit            prev_tv = 0, prev_tr = 0, prev_tok = 0, prev_ov = 0, prev_or = 0;
  logic [W-1:0]  prev_rem;
  int            done_ops = 0;

  always @(posedge clk) edge_cnt++;

  function automatic void model_op(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb, ma, mb, r;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ma = sa < 0 ? -sa : sa;
    mb = sb < 0 ? -sb : sb;
    if (mb == 0) begin
      exp_dbz = 1; exp_rem = W'(ma); exp_q = '1;
    end else begin
      r = ma % mb;
      exp_dbz = 0; exp_rem = W'(sa < 0 ? -r : r); exp_q = W'(ma / mb);
    end
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      busy = 0; toks = 0;
    end else begin
      chk(in_ready == !busy, "R6 in_ready", in_ready, !busy);
      chk(out_valid == (busy && toks == W), "R4 out_valid timing", out_valid, busy && toks == W);
      if (!busy || toks == W) chk(!tok_valid, "R4 no extra token", tok_valid, 0);
      if (prev_tv && !prev_tr) begin
        chk(tok_valid, "R5 token held", tok_valid, 1);
        chk(tok_ok == prev_tok, "R5 token stable", tok_ok, prev_tok);
      end
      if (prev_ov && !prev_or) chk(out_rem == prev_rem, "R7 result held", out_rem, prev_rem);
      if (tok_valid && busy && toks < W)
        chk(tok_ok == exp_q[W-1-toks], "R4 token value", tok_ok, exp_q[W-1-toks]);
      if (out_valid) begin
        if (exp_dbz) begin
          chk(out_rem == exp_rem, "R3 dbz remainder", out_rem, exp_rem);
          chk(out_dbz == 1'b1, "R3 dbz flag", out_dbz, 1);
        end else begin
          chk(out_rem == exp_rem, "R1 R2 remainder", $signed(out_rem), $signed(exp_rem));
          chk(out_dbz == 1'b0, "R7 dbz low", out_dbz, 0);
        end
        if (!lat_checked && !stall_mode) begin
          chk(edge_cnt - hs_edge == longint'(W * STEP_CYC), "R8 latency",
              edge_cnt - hs_edge, W * STEP_CYC);
        end
        lat_checked = 1;
      end
      prev_tv = tok_valid; prev_tr = tok_ready; prev_tok = tok_ok;
      prev_ov = out_valid; prev_or = out_ready; prev_rem = out_rem;
      // handshakes that occur at the coming edge
      if (in_valid && in_ready) begin
        model_op(dividend, divisor);
        busy = 1; toks = 0; hs_edge = edge_cnt + 1; lat_checked = 0;
      end
      if (tok_valid && tok_ready) toks++;
      if (out_valid && out_ready) begin busy = 0; done_ops++; end
    end
  end

  task automatic run_op(input int a, input int b, input bit poke);
    int target;
    @(posedge clk); #1;
    dividend = W'(a); divisor = W'(b); in_valid = 1'b1;
    while (!in_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    target = done_ops + 1;
    in_valid = 1'b0;
    if (poke) begin
      // R6: operands and valid pulses while busy are ignored
      repeat (5) begin
        dividend = W'(32'h1234); divisor = W'(3); in_valid = 1'b1;
        @(posedge clk); #1;
      end
      in_valid = 1'b0;
    end
    while (done_ops < target) begin @(posedge clk); #1; end
  endtask

  task automatic run_all();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid && !tok_valid, "R9 reset state", {in_ready, out_valid, tok_valid}, 3'b100);
    run_op(22, 7, 0);   run_op(-22, 7, 0);  run_op(22, -7, 0);  run_op(-22, -7, 0);
    run_op(7, 22, 0);   run_op(-7, -22, 0); run_op(-7, 22, 0);  run_op(7, -22, 0);
    run_op(0, 0, 0);    run_op(22, 0, 0);   run_op(-22, 0, 0);  run_op(-32768, 0, 0);
    run_op(-32768, -1, 0); run_op(-32768, 7, 0); run_op(5, -32768, 0);
    run_op(-32768, -32768, 0); run_op(32767, 1, 0); run_op(32767, 32767, 0);
    run_op(100, 3, 1);  run_op(-1000, 33, 1);
    stall_mode = 1;
    run_op(12345, -17, 0); run_op(-30000, 255, 0); run_op(-9, 0, 0);
    for (int i = 0; i < 12; i++) run_op(int'(lfsr) - 32768, (i * 977 + 13) % 4000 - 2000, i % 2 == 1);
    stall_mode = 0;
    // R9: clear in the middle of an operation
    @(posedge clk); #1;
    dividend = W'(500); divisor = W'(7); in_valid = 1'b1;
    @(posedge clk); #1; in_valid = 1'b0;
    repeat (20) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid && !tok_valid, "R9 clear mid-op", {in_ready, out_valid, tok_valid}, 3'b100);
    run_op(-50, 9, 0);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule